// File: doc/BRIEF.md
# Three-Event Pin Waveform Formatter

This block shapes a single-bit pin level from one data bit and three timing event strobes, the way a test-pattern pin formatter does. All state lives on one system clock. The events are one-cycle strobes synchronous to that clock. Each event only qualifies register updates, and no register is ever clocked by an event. A two-bit format select picks how the three events move the pin: return-to-zero, complement-surround, or a plain non-return drive.

Event 1 opens a bit period. It takes a snapshot of the data bit and the format select, and that snapshot stays fixed until the next event 1. Events 2 and 3 act on the snapshot, so the data and format inputs may change freely in the middle of a period. When several events land in the same clock cycle, the outcome is fixed by priority. Event 3 outranks event 2, and event 2 outranks event 1. Any event that appears in that cycle's snapshot uses the values present in that same cycle.

Top module: `pin_formatter`

## Requirements
- R1: A synchronous active-high reset drives `pinOut` low. It clears the held data bit to 0 and sets the held format to non-return (2'b00). After reset, an event 2 or 3 with no prior event 1 leaves `pinOut` low.
- R2: In return-to-zero format (`fmtSel` = 2'b01), event 1 (`evtStrobe[0]`) loads `pinOut` with `dataIn`.
- R3: In return-to-zero format, event 2 (`evtStrobe[1]`) drives `pinOut` high.
- R4: In return-to-zero format, event 3 (`evtStrobe[2]`) drives `pinOut` low.
- R5: In complement-surround format (`fmtSel` = 2'b10), event 1 drives `pinOut` to the inverse of `dataIn`.
- R6: In complement-surround format, event 2 drives `pinOut` to the held data bit.
- R7: In complement-surround format, event 3 drives `pinOut` to the inverse of the held data bit.
- R8: In non-return format (`fmtSel` = 2'b00), event 1 loads `pinOut` with `dataIn`, and events 2 and 3 leave `pinOut` unchanged, even when they coincide with event 1.
- R9: In a cycle with no event, `pinOut` holds its value.
- R10: Among events that take effect in the same cycle, the highest-numbered one sets `pinOut`. Any such event uses the `dataIn` and `fmtSel` of that cycle when event 1 is part of it.
- R11: `dataIn` and `fmtSel` are sampled only on event 1. Changes to them in other cycles do not affect what events 2 and 3 produce.
- R12: The format code 2'b11 behaves exactly as non-return.
- R13: Every change of `pinOut` appears on the clock edge that samples the event, one cycle after the strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fmtSel | input | 2 | Format select: 00 non-return, 01 return-to-zero, 10 complement-surround, 11 non-return |
| dataIn | input | 1 | Data bit for the current period |
| evtStrobe | input | 3 | Event strobes; bit 0 is event 1, bit 2 is event 3 |
| pinOut | output | 1 | Registered formatted pin level |

## Verification
Every result is due exactly one clock edge after the cycle that carries the stimulus: the strobe is driven in one cycle, the edge that samples it updates `pinOut`, and nothing else lies in the path. The driver sets inputs on a falling edge. After the next rising edge it pushes the level that a reference model, built from the requirements, expects for that edge. The monitor pops and compares on the following falling edge, so each comparison looks at the register that the matching event updated. Coincident-event and mid-period input-change cases are driven as ordinary steps in the same stream.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  localparam int NUM_EVT = 3;
  localparam int FMT_W   = 2;

  typedef enum logic [FMT_W-1:0] {
    FMT_NRZ = 2'b00,
    FMT_RTZ = 2'b01,
    FMT_SBC = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

  // control-to-datapath strobe bundle
  typedef struct packed {
    logic               capture;   // take a snapshot of data and format
    fmt_e               fmt;       // normalized format in force this cycle
    logic [NUM_EVT-1:0] win;       // one-hot0 winning event
  } strobe_t;

endpackage

// File: rtl/fmt_ctrl.sv
module fmt_ctrl
  import fmt_pkg::*;
#(
  parameter int NEVT = NUM_EVT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] evtStrobe,
  input  logic [FMT_W-1:0] fmtSel,
  input  fmt_e            heldFmt,
  output strobe_t         strb
);

  localparam int LAST = NEVT - 1;

  logic [FMT_W-1:0] rawFmt;
  fmt_e             normFmt;
  logic             lateIgnored;
  logic [NEVT-1:0]  active;
  logic [NEVT-1:0]  winVec;

  // format used in this cycle: fresh on event 1, otherwise the held copy
  always_comb begin
    rawFmt = evtStrobe[0] ? fmtSel : heldFmt;
    case (rawFmt)
      FMT_RTZ: normFmt = FMT_RTZ;
      FMT_SBC: normFmt = FMT_SBC;
      default: normFmt = FMT_NRZ;
    endcase
    lateIgnored = (normFmt == FMT_NRZ);
  end

  // non-return masks every event except the first
  generate
    for (genvar g = 0; g < NEVT; g++) begin : g_mask
      if (g == 0) begin : g_first
        assign active[g] = evtStrobe[g];
      end else begin : g_late
        assign active[g] = evtStrobe[g] & ~lateIgnored;
      end
    end
  endgenerate

  // highest-numbered active event wins
  always_comb begin
    winVec = '0;
    for (int i = LAST; i >= 0; i--) begin
      if (active[i] && (winVec == '0)) winVec[i] = 1'b1;
    end
  end

  always_comb begin
    strb.capture = evtStrobe[0] & ~rst;
    strb.fmt     = normFmt;
    strb.win     = rst ? '0 : winVec;
  end

  logic unusedClk;
  assign unusedClk = clk;

endmodule

// File: rtl/fmt_datapath.sv
module fmt_datapath
  import fmt_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           dataIn,
  input  logic [FMT_W-1:0] fmtSel,
  input  strobe_t        strb,
  output fmt_e           heldFmt,
  output logic           pinOut
);

  logic heldData;
  logic effData;
  logic nextLevel;

  assign effData = strb.capture ? dataIn : heldData;

  always_comb begin
    nextLevel = pinOut;
    if (strb.win[2]) begin
      case (strb.fmt)
        FMT_RTZ: nextLevel = 1'b0;
        FMT_SBC: nextLevel = ~effData;
        default: nextLevel = pinOut;
      endcase
    end else if (strb.win[1]) begin
      case (strb.fmt)
        FMT_RTZ: nextLevel = 1'b1;
        FMT_SBC: nextLevel = effData;
        default: nextLevel = pinOut;
      endcase
    end else if (strb.win[0]) begin
      case (strb.fmt)
        FMT_SBC: nextLevel = ~effData;
        default: nextLevel = effData;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      heldData <= 1'b0;
      heldFmt  <= FMT_NRZ;
      pinOut   <= 1'b0;
    end else begin
      if (strb.capture) begin
        heldData <= dataIn;
        heldFmt  <= fmt_e'(fmtSel);
      end
      pinOut <= nextLevel;
    end
  end

endmodule

// File: rtl/pin_formatter.sv
module pin_formatter
  import fmt_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   fmtSel,
  input  logic         dataIn,
  input  logic [2:0]   evtStrobe,
  output logic         pinOut
);

  strobe_t strb;
  fmt_e    heldFmt;

  fmt_ctrl #(.NEVT(NUM_EVT)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .evtStrobe (evtStrobe),
    .fmtSel    (fmtSel),
    .heldFmt   (heldFmt),
    .strb      (strb)
  );

  fmt_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .dataIn  (dataIn),
    .fmtSel  (fmtSel),
    .strb    (strb),
    .heldFmt (heldFmt),
    .pinOut  (pinOut)
  );

endmodule

// File: rtl/fmt_checker.sv
module fmt_checker
  import fmt_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [1:0] fmtSel,
  input logic       dataIn,
  input logic [2:0] evtStrobe,
  input logic       pinOut,
  input strobe_t    strb
);

  p_reset_low_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pinOut);

  p_rtz_load_r2: assert property (@(posedge clk) disable iff (rst)
    (evtStrobe == 3'b001 && fmtSel == FMT_RTZ) |=> pinOut == $past(dataIn));

  p_sbc_first_r5: assert property (@(posedge clk) disable iff (rst)
    (evtStrobe == 3'b001 && fmtSel == FMT_SBC) |=> pinOut == !$past(dataIn));

  p_nrz_load_r8: assert property (@(posedge clk) disable iff (rst)
    (evtStrobe[0] && fmtSel == FMT_NRZ) |=> pinOut == $past(dataIn));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (evtStrobe == 3'b000) |=> $stable(pinOut));

  p_one_winner_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.win));

  p_third_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (evtStrobe == 3'b111 && fmtSel == FMT_RTZ) |=> !pinOut);

endmodule

bind pin_formatter fmt_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .fmtSel    (fmtSel),
  .dataIn    (dataIn),
  .evtStrobe (evtStrobe),
  .pinOut    (pinOut),
  .strb      (strb)
);

// File: tb/test_pin_formatter.sv
`timescale 1ns/1ps
module test_pin_formatter;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] fmtSel;
  logic       dataIn;
  logic [2:0] evtStrobe;
  logic       pinOut;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bit    expQ[$];
  string tagQ[$];

  // reference model state
  bit       mOut;
  bit       mData;
  bit [1:0] mFmt;

  always #4 clk = ~clk;

  pin_formatter i_pin_formatter (
    .clk       (clk),
    .rst       (rst),
    .fmtSel    (fmtSel),
    .dataIn    (dataIn),
    .evtStrobe (evtStrobe),
    .pinOut    (pinOut)
  );

  // one stimulus cycle; expected level is pushed after the sampling edge
  task automatic step(input bit r, input bit [1:0] f, input bit d,
                      input bit [2:0] e, input string tag);
    bit       effD;
    bit [1:0] effF;
    bit       nxt;
    @(negedge clk);
    rst = r; fmtSel = f; dataIn = d; evtStrobe = e;
    if (r) begin
      nxt = 1'b0; mData = 1'b0; mFmt = 2'b00;
    end else begin
      effD = e[0] ? d : mData;
      effF = e[0] ? f : mFmt;
      if (effF == 2'b11) effF = 2'b00;
      nxt = mOut;
      if (e[0]) nxt = (effF == 2'b10) ? ~effD : effD;
      if (e[1] && effF == 2'b01) nxt = 1'b1;
      if (e[1] && effF == 2'b10) nxt = effD;
      if (e[2] && effF == 2'b01) nxt = 1'b0;
      if (e[2] && effF == 2'b10) nxt = ~effD;
      if (e[0]) begin mData = d; mFmt = f; end
    end
    mOut = nxt;
    @(posedge clk);
    #1;
    expQ.push_back(nxt);
    tagQ.push_back(tag);
  endtask

  // monitor: compare one edge's result per falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      bit    ex;
      string tg;
      ex = expQ.pop_front();
      tg = tagQ.pop_front();
      total++;
      if (pinOut !== ex) begin
        bad++;
        $display("FAIL %s: pinOut=%b expected=%b", tg, pinOut, ex);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; fmtSel = 2'b00; dataIn = 1'b0; evtStrobe = 3'b000;
    mOut = 0; mData = 0; mFmt = 0;
    step(1, 2'b00, 0, 3'b000, "R1 reset");
    step(1, 2'b01, 1, 3'b111, "R1 reset with events");
    // R1: late events before any event 1 keep the pin low
    step(0, 2'b01, 1, 3'b010, "R1 evt2 after reset");
    step(0, 2'b10, 1, 3'b100, "R1 evt3 after reset");
    // R2 R3 R4 R13 return-to-zero period, data 0 then 1
    step(0, 2'b01, 0, 3'b001, "R2 rtz load 0");
    step(0, 2'b01, 0, 3'b010, "R3 rtz high");
    step(0, 2'b01, 0, 3'b000, "R9 hold high");
    step(0, 2'b01, 0, 3'b100, "R4 rtz low");
    step(0, 2'b01, 1, 3'b001, "R2 rtz load 1");
    step(0, 2'b01, 0, 3'b000, "R9 hold");
    step(0, 2'b01, 0, 3'b100, "R4 rtz low again");
    // R5 R6 R7 complement-surround, data 1 then 0
    step(0, 2'b10, 1, 3'b001, "R5 sbc first");
    step(0, 2'b10, 0, 3'b010, "R6 sbc middle held data");
    step(0, 2'b10, 0, 3'b100, "R7 sbc last");
    step(0, 2'b10, 0, 3'b001, "R5 sbc first d0");
    step(0, 2'b01, 1, 3'b010, "R11 sbc middle ignores new inputs");
    step(0, 2'b00, 1, 3'b100, "R7 sbc last d0");
    // R8 non-return ignores late events
    step(0, 2'b00, 1, 3'b001, "R8 nrz load 1");
    step(0, 2'b00, 0, 3'b100, "R8 nrz evt3 ignored");
    step(0, 2'b00, 0, 3'b010, "R8 nrz evt2 ignored");
    step(0, 2'b00, 0, 3'b111, "R8 nrz coincident load 0");
    // R12 reserved code acts as non-return
    step(0, 2'b11, 1, 3'b001, "R12 rsv load");
    step(0, 2'b01, 0, 3'b100, "R12 rsv evt3 ignored");
    step(0, 2'b01, 0, 3'b010, "R12 rsv evt2 ignored");
    // R10 coincident events
    step(0, 2'b01, 1, 3'b111, "R10 rtz all three low");
    step(0, 2'b01, 0, 3'b011, "R10 rtz 1+2 high");
    step(0, 2'b01, 1, 3'b101, "R10 rtz 1+3 low");
    step(0, 2'b10, 1, 3'b011, "R10 sbc 1+2 fresh data");
    step(0, 2'b10, 1, 3'b101, "R10 sbc 1+3 fresh data");
    step(0, 2'b10, 0, 3'b110, "R10 sbc 2+3 held data");
    // R11 format changes mid-period are ignored
    step(0, 2'b10, 0, 3'b001, "R11 capture sbc d0");
    step(0, 2'b01, 1, 3'b100, "R11 evt3 uses held sbc");
    step(0, 2'b00, 1, 3'b010, "R11 evt2 uses held sbc");
    // R1 reset mid-stream
    step(1, 2'b01, 1, 3'b011, "R1 reset mid-stream");
    step(0, 2'b10, 1, 3'b010, "R1 evt2 after second reset");
    step(0, 2'b00, 0, 3'b000, "R9 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule